// File: doc/BRIEF.md
# Integer Execute Unit with Signed-Overflow Flag

This block is the integer datapath of a load/store RISC pipeline's execute stage. It is purely combinational: given two register operands, the 16-bit immediate field, the 5-bit shift-amount field and an operation code, it returns a 32-bit result and a flag that marks two's-complement overflow. It does not raise a trap itself. A later pipeline stage decides what to do when the flag is set.

The unit widens the immediate on its own, and the kind of widening depends on the operation. Bitwise immediates receive zero fill. Both add-immediate forms receive sign fill. Shifts act on the second operand. The shift distance comes either from the instruction field or from the low bits of the first operand. The upper-immediate operation builds a constant whose top half is the immediate.

Top module: `exu_int_core`

## Requirements
- R1: The checked forms set `ovf_o` exactly when the true signed result does not fit in 32 bits. These forms are add (op 0, a+b), subtract (op 2, a-b) and add-immediate (op 4, a+sign-extended imm).
- R2: `ovf_o` stays 0 for every other opcode, including the wrapping forms: add (op 1), subtract (op 3) and add-immediate (op 5). It also stays 0 for all bitwise operations and all shifts.
- R3: For ops 0 to 5 the result is always the 32-bit modular sum or difference, even when `ovf_o` is 1.
- R4: The bitwise-immediate ops use the immediate with bits 31:16 cleared. These are AND (op 10), OR (op 11) and XOR (op 12), each applied with operand a.
- R5: Both add-immediate ops (4 and 5) copy immediate bit 15 into bits 31:16.
- R6: The register bitwise ops compute a AND b (op 6), a OR b (op 7), a XOR b (op 8) and NOT(a OR b) (op 9).
- R7: The fixed shifts act on b by `shamt_i`. Left logical (op 13) and right logical (op 14) fill with zeros. Right arithmetic (op 15) fills with b[31].
- R8: The variable shifts use a[4:0] as the distance, and `shamt_i` and a[31:5] have no effect. They are left (op 16), right logical (op 17) and right arithmetic (op 18).
- R9: Op 19 returns the immediate in bits 31:16 and zeros in bits 15:0.
- R10: Opcodes 20 to 31 return a zero result with `ovf_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| src_a_i | input | 32 | First register operand, and the distance source for variable shifts |
| src_b_i | input | 32 | Second register operand, and the shifted value |
| imm_i | input | 16 | Immediate field |
| shamt_i | input | 5 | Shift distance for the fixed shifts |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed overflow indication |

## Verification
The hardest corner to reach is subtraction overflow. There, the inverted second operand, rather than the raw one, must share the first operand's sign, and the wrapped difference must still appear on the result. The stimulus subtracts the most negative value from zero and subtracts one from the most negative value. It also feeds add-immediate a negative immediate against the most negative operand, so that sign extension alone causes the overflow. The same boundary operands are then sent through the wrapping forms to show the flag stays clear while the result stays identical.

// File: rtl/exu_int_pkg.sv
package exu_int_pkg;
   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_ADD_CHK   = 5'd0,
      OP_ADD_WRAP  = 5'd1,
      OP_SUB_CHK   = 5'd2,
      OP_SUB_WRAP  = 5'd3,
      OP_ADDI_CHK  = 5'd4,
      OP_ADDI_WRAP = 5'd5,
      OP_AND       = 5'd6,
      OP_OR        = 5'd7,
      OP_XOR       = 5'd8,
      OP_NOR       = 5'd9,
      OP_ANDI      = 5'd10,
      OP_ORI       = 5'd11,
      OP_XORI      = 5'd12,
      OP_SHL       = 5'd13,
      OP_SHR       = 5'd14,
      OP_SHRA      = 5'd15,
      OP_SHL_V     = 5'd16,
      OP_SHR_V     = 5'd17,
      OP_SHRA_V    = 5'd18,
      OP_UPPER     = 5'd19
   } exu_op_e;
endpackage

// File: rtl/exu_imm_widen.sv
module exu_imm_widen #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic [IMM_W-1:0]  imm_i,
   input  logic              sign_fill_i,
   output logic [DATA_W-1:0] wide_o
);
   localparam int FILL_W = DATA_W - IMM_W;

   if (FILL_W < 1) begin : g_bad_width
      $error("exu_imm_widen: DATA_W must exceed IMM_W");
   end

   logic fill_bit;
   assign fill_bit = sign_fill_i & imm_i[IMM_W-1];
   assign wide_o   = {{FILL_W{fill_bit}}, imm_i};
endmodule

// File: rtl/exu_addsub.sv
module exu_addsub #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sub_i,
   input  logic              chk_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              ovf_o
);
   logic [DATA_W-1:0] b_eff;
   logic              same_in;

   assign b_eff   = sub_i ? ~b_i : b_i;
   assign sum_o   = a_i + b_eff + {{(DATA_W-1){1'b0}}, sub_i};
   assign same_in = (a_i[DATA_W-1] == b_eff[DATA_W-1]);
   assign ovf_o   = chk_i & same_in & (sum_o[DATA_W-1] != a_i[DATA_W-1]);

   // independent reference: one-bit-wider signed arithmetic
   logic [DATA_W:0] ref_wide;
   always_comb begin
      if (sub_i) ref_wide = {a_i[DATA_W-1], a_i} - {b_i[DATA_W-1], b_i};
      else       ref_wide = {a_i[DATA_W-1], a_i} + {b_i[DATA_W-1], b_i};
      AST_OVF_MATCHES_WIDE: assert (!chk_i || (ovf_o == (ref_wide[DATA_W] != ref_wide[DATA_W-1])))
         else $error("overflow disagrees with wide arithmetic"); // R1
      AST_SUM_IS_WRAPPED: assert (sum_o == ref_wide[DATA_W-1:0])
         else $error("sum is not the modular result"); // R3
   end
endmodule

// File: rtl/exu_shifter.sv
module exu_shifter #(
   parameter int DATA_W  = 32,
   parameter int SHAMT_W = 5,
   parameter bit BARREL  = 1'b1
) (
   input  logic [DATA_W-1:0]  val_i,
   input  logic [SHAMT_W-1:0] amt_i,
   input  logic               right_i,
   input  logic               arith_i,
   output logic [DATA_W-1:0]  res_o
);
   if ((1 << SHAMT_W) != DATA_W) begin : g_bad_amt
      $error("exu_shifter: SHAMT_W must equal log2(DATA_W)");
   end

   logic fill;
   assign fill = arith_i & val_i[DATA_W-1];

   if (BARREL) begin : g_barrel
      logic [SHAMT_W:0][DATA_W-1:0] lft;
      logic [SHAMT_W:0][DATA_W-1:0] rgt;
      assign lft[0] = val_i;
      assign rgt[0] = val_i;
      for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
         localparam int DIST = 1 << k;
         logic [DATA_W-1:0] top_mask;
         assign top_mask = ~({DATA_W{1'b1}} >> DIST);
         assign lft[k+1] = amt_i[k] ? (lft[k] << DIST) : lft[k];
         assign rgt[k+1] = amt_i[k] ? ((rgt[k] >> DIST) | (top_mask & {DATA_W{fill}}))
                                    : rgt[k];
      end
      assign res_o = right_i ? rgt[SHAMT_W] : lft[SHAMT_W];
   end else begin : g_operator
      logic signed [DATA_W:0] ext;
      logic signed [DATA_W:0] shr;
      assign ext   = {fill, val_i};
      assign shr   = ext >>> amt_i;
      assign res_o = right_i ? shr[DATA_W-1:0] : (val_i << amt_i);
   end

   always_comb begin
      AST_ARITH_FILL: assert (!(right_i && arith_i && val_i[DATA_W-1]) || res_o[DATA_W-1])
         else $error("arithmetic right shift lost the sign"); // R7
      AST_LOGIC_FILL: assert (!(right_i && !arith_i && amt_i != '0) || !res_o[DATA_W-1])
         else $error("logical right shift did not zero fill"); // R7
   end
endmodule

// File: rtl/exu_int_core.sv
module exu_int_core
   import exu_int_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int IMM_W   = 16,
   parameter int SHAMT_W = 5,
   parameter bit BARREL  = 1'b1
) (
   input  logic [OP_W-1:0]    op_i,
   input  logic [DATA_W-1:0]  src_a_i,
   input  logic [DATA_W-1:0]  src_b_i,
   input  logic [IMM_W-1:0]   imm_i,
   input  logic [SHAMT_W-1:0] shamt_i,
   output logic [DATA_W-1:0]  result_o,
   output logic               ovf_o
);
   localparam int LOW_W = DATA_W - IMM_W;

   if (2 * IMM_W > DATA_W) begin : g_bad_imm
      $error("exu_int_core: immediate wider than half the datapath");
   end

   exu_op_e op;
   assign op = exu_op_e'(op_i);

   // immediate widening
   logic              imm_signed;
   logic [DATA_W-1:0] imm_wide;
   assign imm_signed = (op == OP_ADDI_CHK) || (op == OP_ADDI_WRAP);

   exu_imm_widen #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_widen (
      .imm_i       (imm_i),
      .sign_fill_i (imm_signed),
      .wide_o      (imm_wide)
   );

   // adder
   logic              as_sub, as_chk, as_ovf;
   logic [DATA_W-1:0] as_b, as_sum;
   assign as_sub = (op == OP_SUB_CHK) || (op == OP_SUB_WRAP);
   assign as_chk = (op == OP_ADD_CHK) || (op == OP_SUB_CHK) || (op == OP_ADDI_CHK);
   assign as_b   = imm_signed ? imm_wide : src_b_i;

   exu_addsub #(.DATA_W(DATA_W)) u_addsub (
      .a_i   (src_a_i),
      .b_i   (as_b),
      .sub_i (as_sub),
      .chk_i (as_chk),
      .sum_o (as_sum),
      .ovf_o (as_ovf)
   );

   // shifter
   logic               sh_var, sh_right, sh_arith;
   logic [SHAMT_W-1:0] sh_amt;
   logic [DATA_W-1:0]  sh_res;
   assign sh_var   = (op == OP_SHL_V) || (op == OP_SHR_V) || (op == OP_SHRA_V);
   assign sh_right = (op == OP_SHR) || (op == OP_SHRA) || (op == OP_SHR_V) || (op == OP_SHRA_V);
   assign sh_arith = (op == OP_SHRA) || (op == OP_SHRA_V);
   assign sh_amt   = sh_var ? src_a_i[SHAMT_W-1:0] : shamt_i;

   exu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .BARREL(BARREL)) u_shift (
      .val_i   (src_b_i),
      .amt_i   (sh_amt),
      .right_i (sh_right),
      .arith_i (sh_arith),
      .res_o   (sh_res)
   );

   // bitwise operand: register or zero-filled immediate
   logic [DATA_W-1:0] lg_b;
   assign lg_b = ((op == OP_ANDI) || (op == OP_ORI) || (op == OP_XORI)) ? imm_wide : src_b_i;

   always_comb begin
      result_o = '0;
      ovf_o    = 1'b0;
      unique case (op)
         OP_ADD_CHK, OP_SUB_CHK, OP_ADDI_CHK: begin
            result_o = as_sum;
            ovf_o    = as_ovf;
         end
         OP_ADD_WRAP, OP_SUB_WRAP, OP_ADDI_WRAP: result_o = as_sum;
         OP_AND, OP_ANDI: result_o = src_a_i & lg_b;
         OP_OR,  OP_ORI:  result_o = src_a_i | lg_b;
         OP_XOR, OP_XORI: result_o = src_a_i ^ lg_b;
         OP_NOR:          result_o = ~(src_a_i | lg_b);
         OP_SHL, OP_SHR, OP_SHRA, OP_SHL_V, OP_SHR_V, OP_SHRA_V: result_o = sh_res;
         OP_UPPER:        result_o = {imm_i, {LOW_W{1'b0}}};
         default: begin
            result_o = '0;
            ovf_o    = 1'b0;
         end
      endcase
   end

   always_comb begin
      AST_NO_OVERFLOW: assert (!ovf_o || (op == OP_ADD_CHK) || (op == OP_SUB_CHK) || (op == OP_ADDI_CHK))
         else $error("overflow on a non-checking op"); // R2
      AST_ZERO_FILL_IMM: assert (!((op == OP_ANDI) || (op == OP_ORI) || (op == OP_XORI))
                                 || ((result_o ^ src_a_i) & ~{{LOW_W{1'b0}}, {IMM_W{1'b1}}}) == '0
                                 || op == OP_ANDI)
         else $error("bitwise immediate changed upper bits"); // R4
      AST_ANDI_UPPER_CLEAR: assert (op != OP_ANDI || result_o[DATA_W-1:IMM_W] == '0)
         else $error("and-immediate left upper bits set"); // R4
      AST_UPPER_LOW_CLEAR: assert (op != OP_UPPER || result_o[LOW_W-1:0] == '0)
         else $error("upper-immediate low half not cleared"); // R9
      AST_UNUSED_IDLE: assert (op_i < OP_W'(20) || (result_o == '0 && !ovf_o))
         else $error("unused opcode produced output"); // R10
   end
endmodule

// File: tb/exu_int_core_test.sv
module exu_int_core_test;
   import exu_int_pkg::*;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [4:0]  op;
   logic [31:0] a, b;
   logic [15:0] imm;
   logic [4:0]  shamt;
   logic [31:0] result;
   logic        ovf;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   exu_int_core uut (
      .op_i     (op),
      .src_a_i  (a),
      .src_b_i  (b),
      .imm_i    (imm),
      .shamt_i  (shamt),
      .result_o (result),
      .ovf_o    (ovf)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000 && !done) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run did not complete, actual cycles %0d expected < 20000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic drive(input logic [4:0] o, input logic [31:0] aa, input logic [31:0] bb,
                        input logic [15:0] ii, input logic [4:0] ss);
      @(negedge clk);
      op = o; a = aa; b = bb; imm = ii; shamt = ss;
      #1;
   endtask

   task automatic expect_out(input string req, input logic [31:0] exp_r, input logic exp_o);
      checks = checks + 1;
      if (result !== exp_r || ovf !== exp_o) begin
         errors = errors + 1;
         $display("FAIL %s: actual result %h ovf %b, expected result %h ovf %b",
                  req, result, ovf, exp_r, exp_o);
      end
   endtask

   task automatic t_idle;
      drive(5'd0, 32'h0, 32'h0, 16'h0, 5'd0);
      expect_out("R3 idle zero inputs", 32'h0, 1'b0);
   endtask

   task automatic t_signed_overflow;
      drive(OP_ADD_CHK, 32'h7fffffff, 32'h1, 16'h0, 5'd0);
      expect_out("R1/R3 add max+1", 32'h80000000, 1'b1);
      drive(OP_ADD_CHK, 32'hffffffff, 32'h1, 16'h0, 5'd0);
      expect_out("R1 add -1+1", 32'h0, 1'b0);
      drive(OP_ADD_CHK, 32'h80000000, 32'h80000000, 16'h0, 5'd0);
      expect_out("R1/R3 add min+min", 32'h0, 1'b1);
      drive(OP_SUB_CHK, 32'h80000000, 32'h1, 16'h0, 5'd0);
      expect_out("R1/R3 sub min-1", 32'h7fffffff, 1'b1);
      drive(OP_SUB_CHK, 32'h0, 32'h80000000, 16'h0, 5'd0);
      expect_out("R1/R3 sub 0-min", 32'h80000000, 1'b1);
      drive(OP_SUB_CHK, 32'hffffffff, 32'h80000000, 16'h0, 5'd0);
      expect_out("R1 sub -1-min fits", 32'h7fffffff, 1'b0);
      drive(OP_SUB_CHK, 32'd5, 32'd3, 16'h0, 5'd0);
      expect_out("R1 sub 5-3", 32'd2, 1'b0);
      drive(OP_ADDI_CHK, 32'h7fffffff, 32'h0, 16'h0001, 5'd0);
      expect_out("R1 addi max+1", 32'h80000000, 1'b1);
      drive(OP_ADDI_CHK, 32'h80000000, 32'h0, 16'hffff, 5'd0);
      expect_out("R1/R5 addi min+(-1)", 32'h7fffffff, 1'b1);
   endtask

   task automatic t_wrapping;
      drive(OP_ADD_WRAP, 32'h7fffffff, 32'h1, 16'h0, 5'd0);
      expect_out("R2/R3 wrap add max+1", 32'h80000000, 1'b0);
      drive(OP_SUB_WRAP, 32'h0, 32'h1, 16'h0, 5'd0);
      expect_out("R2/R3 wrap sub 0-1", 32'hffffffff, 1'b0);
      drive(OP_SUB_WRAP, 32'h80000000, 32'h1, 16'h0, 5'd0);
      expect_out("R2 wrap sub min-1", 32'h7fffffff, 1'b0);
      drive(OP_ADDI_WRAP, 32'd16, 32'h0, 16'hfff0, 5'd0);
      expect_out("R5 wrap addi 16+(-16)", 32'h0, 1'b0);
      drive(OP_ADDI_WRAP, 32'h7fffffff, 32'h0, 16'h7fff, 5'd0);
      expect_out("R2/R5 wrap addi positive imm", 32'h80007ffe, 1'b0);
   endtask

   task automatic t_bitwise;
      drive(OP_AND, 32'hf0f0_ff00, 32'h0ff0_f0f0, 16'hffff, 5'd0);
      expect_out("R6 and", 32'h00f0_f000, 1'b0);
      drive(OP_OR, 32'hf0f0_0000, 32'h0000_0f0f, 16'h0, 5'd0);
      expect_out("R6 or", 32'hf0f0_0f0f, 1'b0);
      drive(OP_XOR, 32'hffff_0000, 32'hff00_ff00, 16'h0, 5'd0);
      expect_out("R6 xor", 32'h00ff_ff00, 1'b0);
      drive(OP_NOR, 32'h8000_0001, 32'h0000_0100, 16'h0, 5'd0);
      expect_out("R6 nor", 32'h7fff_fefe, 1'b0);
      drive(OP_NOR, 32'h0, 32'h0, 16'h0, 5'd0);
      expect_out("R2/R6 nor all ones no flag", 32'hffffffff, 1'b0);
   endtask

   task automatic t_bitwise_imm;
      drive(OP_ANDI, 32'hffffffff, 32'h12345678, 16'h8001, 5'd0);
      expect_out("R4 andi zero fill", 32'h0000_8001, 1'b0);
      drive(OP_ORI, 32'h0, 32'hffffffff, 16'hffff, 5'd0);
      expect_out("R4 ori zero fill", 32'h0000_ffff, 1'b0);
      drive(OP_XORI, 32'hffff_0000, 32'h0, 16'hffff, 5'd0);
      expect_out("R4 xori zero fill", 32'hffff_ffff, 1'b0);
   endtask

   task automatic t_fixed_shift;
      drive(OP_SHL, 32'h0, 32'h1, 16'h0, 5'd31);
      expect_out("R7 left by 31", 32'h8000_0000, 1'b0);
      drive(OP_SHR, 32'h0, 32'h8000_0000, 16'h0, 5'd4);
      expect_out("R7 right logical", 32'h0800_0000, 1'b0);
      drive(OP_SHRA, 32'h0, 32'h8000_0000, 16'h0, 5'd4);
      expect_out("R7 right arith negative", 32'hf800_0000, 1'b0);
      drive(OP_SHRA, 32'h0, 32'h4000_0000, 16'h0, 5'd4);
      expect_out("R7 right arith positive", 32'h0400_0000, 1'b0);
      drive(OP_SHRA, 32'h0, 32'h8000_0000, 16'h0, 5'd31);
      expect_out("R7 right arith by 31", 32'hffff_ffff, 1'b0);
      drive(OP_SHR, 32'h0, 32'hdead_beef, 16'h0, 5'd0);
      expect_out("R7 shift by zero", 32'hdead_beef, 1'b0);
   endtask

   task automatic t_var_shift;
      drive(OP_SHL_V, 32'h0000_0023, 32'h1, 16'h0, 5'd7);
      expect_out("R8 variable left uses a[4:0]", 32'h0000_0008, 1'b0);
      drive(OP_SHRA_V, 32'hffff_ffe1, 32'h8000_0000, 16'h0, 5'd9);
      expect_out("R8 variable arith right", 32'hc000_0000, 1'b0);
      drive(OP_SHR_V, 32'hffff_ff20, 32'hcafe_f00d, 16'h0, 5'd31);
      expect_out("R8 variable right distance zero", 32'hcafe_f00d, 1'b0);
      drive(OP_SHR_V, 32'h0000_0008, 32'h8000_0000, 16'h0, 5'd1);
      expect_out("R8 variable right logical", 32'h0080_0000, 1'b0);
   endtask

   task automatic t_upper;
      drive(OP_UPPER, 32'hffffffff, 32'hffffffff, 16'habcd, 5'd3);
      expect_out("R9 upper immediate", 32'habcd_0000, 1'b0);
      drive(OP_UPPER, 32'h0, 32'h0, 16'h8000, 5'd0);
      expect_out("R9 upper immediate msb", 32'h8000_0000, 1'b0);
   endtask

   task automatic t_unused;
      for (int c = 20; c < 32; c++) begin
         drive(5'(c), 32'h7fffffff, 32'h1, 16'hffff, 5'd1);
         expect_out("R10 unused opcode", 32'h0, 1'b0);
      end
   endtask

   initial begin
      op = '0; a = '0; b = '0; imm = '0; shamt = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_idle();
      t_signed_overflow();
      t_wrapping();
      t_bitwise();
      t_bitwise_imm();
      t_fixed_shift();
      t_var_shift();
      t_upper();
      t_unused();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule